// File: doc/BRIEF.md
# Downstream Credit Tracker

This block sits beside the rename stage of an out-of-order core and decides, per hardware thread, how many instructions may be renamed in the current cycle. It holds a local copy of the free entry count of the reorder buffer, the issue queue and the load/store queue. Each copy is refreshed only when a report for it arrives, and reports arrive late. Instructions that rename has already sent but that have not yet been dispatched are not yet reflected in these reports. A per-thread in-flight counter tracks them, and the block subtracts it from each copy.

Each cycle the block forms three effective free counts and takes the smallest. It caps that value at the number of instructions waiting. It raises a block flag when the waiting instructions cannot all go, and it names the structure that set the limit so that full events can be counted against it. Threads share no state.

Top module: `credit_tracker`

## Requirements
- R1: The effective free count of the reorder buffer and of the issue queue is its stored count minus (in-flight count minus `disp_cnt` of this cycle).
- R2: The effective free count of the load/store queue is its stored count minus (in-flight count minus `lsq_disp_cnt` of this cycle). `disp_cnt` has no effect on it.
- R3: At each clock edge the in-flight count becomes in-flight plus `ren_cnt` minus `disp_cnt`. When that value would be negative, the count becomes zero.
- R4: `allow_cnt` is the smallest effective free count, capped at `avail_cnt`. `block` is high exactly when `avail_cnt` is nonzero and that smallest count is below `avail_cnt`.
- R5: When the smallest effective free count is zero or negative, `allow_cnt` is 0. `block` is then high whenever `avail_cnt` is nonzero.
- R6: `limiter` names the structure with the smallest effective count, encoded 0 = reorder buffer, 1 = issue queue, 2 = load/store queue. On equal counts the lower code wins.
- R7: A stored free count is replaced by its report value at a clock edge only when that report's valid bit is high. A report value without its valid bit has no effect.
- R8: `rob_empty` takes the value of `rob_empty_in` at each edge where the reorder buffer report is valid, and otherwise holds.
- R9: After reset the stored counts equal the parameters `ROB_INIT`, `IQ_INIT` and `LSQ_INIT`, the in-flight count is zero and `rob_empty` is 1.
- R10: Thread t uses slice t of every vector port, packed from bit 0 upward. Inputs of one thread have no effect on the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rob_vld | input | THREADS | Reorder buffer report valid, one bit per thread |
| rob_free | input | THREADS*CNT_W | Reported free reorder buffer entries |
| rob_empty_in | input | THREADS | Reported reorder buffer empty state |
| iq_vld | input | THREADS | Issue queue report valid |
| iq_free | input | THREADS*CNT_W | Reported free issue queue entries |
| lsq_vld | input | THREADS | Load/store queue report valid |
| lsq_free | input | THREADS*CNT_W | Reported free load/store queue entries |
| disp_cnt | input | THREADS*WIDTH_W | Instructions dispatched this cycle |
| lsq_disp_cnt | input | THREADS*WIDTH_W | Instructions dispatched to the load/store queue this cycle |
| avail_cnt | input | THREADS*WIDTH_W | Instructions waiting to be renamed |
| ren_cnt | input | THREADS*WIDTH_W | Instructions renamed this cycle |
| allow_cnt | output | THREADS*WIDTH_W | Instructions that may be renamed this cycle |
| block | output | THREADS | Rename must stall this cycle |
| limiter | output | THREADS*2 | Structure that limits the count |
| rob_empty | output | THREADS | Stored reorder buffer empty flag |

## Verification
A rename and a dispatch can land in the same cycle, both on the in-flight counter and on the credit computation. The bench drives nonzero `ren_cnt` and `disp_cnt` into one edge. It then checks, before and after that edge, that the current dispatch already returns credit and that the net in-flight change is the difference of the two. A fresh report and a nonzero dispatch also coincide in one cycle. The following cycle is judged against the new snapshot corrected by the updated counter.

// File: rtl/credit_tracker.sv
module credit_tracker #(
  parameter int THREADS  = 2,
  parameter int CNT_W    = 6,
  parameter int INFL_W   = 8,
  parameter int WIDTH_W  = 4,
  parameter int ROB_INIT = 32,
  parameter int IQ_INIT  = 16,
  parameter int LSQ_INIT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [THREADS-1:0]         rob_vld,
  input  logic [THREADS*CNT_W-1:0]   rob_free,
  input  logic [THREADS-1:0]         rob_empty_in,
  input  logic [THREADS-1:0]         iq_vld,
  input  logic [THREADS*CNT_W-1:0]   iq_free,
  input  logic [THREADS-1:0]         lsq_vld,
  input  logic [THREADS*CNT_W-1:0]   lsq_free,
  input  logic [THREADS*WIDTH_W-1:0] disp_cnt,
  input  logic [THREADS*WIDTH_W-1:0] lsq_disp_cnt,
  input  logic [THREADS*WIDTH_W-1:0] avail_cnt,
  input  logic [THREADS*WIDTH_W-1:0] ren_cnt,
  output logic [THREADS*WIDTH_W-1:0] allow_cnt,
  output logic [THREADS-1:0]         block,
  output logic [THREADS*2-1:0]       limiter,
  output logic [THREADS-1:0]         rob_empty
);
  localparam int EW = ((INFL_W > CNT_W) ? INFL_W : CNT_W) + 2;

  logic [CNT_W-1:0]  rob_q  [THREADS];
  logic [CNT_W-1:0]  iq_q   [THREADS];
  logic [CNT_W-1:0]  lsq_q  [THREADS];
  logic [INFL_W-1:0] infl_q [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [WIDTH_W-1:0] dsp, ldsp, av, ren;
    logic signed [EW-1:0] s_inf, s_dsp, s_ldsp, s_av;
    logic signed [EW-1:0] rob_e, iq_e, lsq_e, mn;
    logic [1:0] lim;
    logic [INFL_W:0] sum;

    assign dsp  = disp_cnt[t*WIDTH_W +: WIDTH_W];
    assign ldsp = lsq_disp_cnt[t*WIDTH_W +: WIDTH_W];
    assign av   = avail_cnt[t*WIDTH_W +: WIDTH_W];
    assign ren  = ren_cnt[t*WIDTH_W +: WIDTH_W];

    assign s_inf  = EW'(infl_q[t]);
    assign s_dsp  = EW'(dsp);
    assign s_ldsp = EW'(ldsp);
    assign s_av   = EW'(av);

    assign rob_e = EW'(rob_q[t]) - (s_inf - s_dsp);
    assign iq_e  = EW'(iq_q[t])  - (s_inf - s_dsp);
    assign lsq_e = EW'(lsq_q[t]) - (s_inf - s_ldsp);

    always_comb begin
      if (rob_e <= iq_e && rob_e <= lsq_e) begin
        lim = 2'd0; mn = rob_e;
      end else if (iq_e <= lsq_e) begin
        lim = 2'd1; mn = iq_e;
      end else begin
        lim = 2'd2; mn = lsq_e;
      end
    end

    assign limiter[t*2 +: 2] = lim;
    assign block[t] = (av != '0) && (mn < s_av);
    assign allow_cnt[t*WIDTH_W +: WIDTH_W] =
      (mn <= 0) ? '0 : (mn < s_av) ? mn[WIDTH_W-1:0] : av;

    assign sum = (INFL_W+1)'(infl_q[t]) + (INFL_W+1)'(ren);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rob_q[t]     <= CNT_W'(ROB_INIT);
        iq_q[t]      <= CNT_W'(IQ_INIT);
        lsq_q[t]     <= CNT_W'(LSQ_INIT);
        infl_q[t]    <= '0;
        rob_empty[t] <= 1'b1;
      end else begin
        if (rob_vld[t]) begin
          rob_q[t]     <= rob_free[t*CNT_W +: CNT_W];
          rob_empty[t] <= rob_empty_in[t];
        end
        if (iq_vld[t])  iq_q[t]  <= iq_free[t*CNT_W +: CNT_W];
        if (lsq_vld[t]) lsq_q[t] <= lsq_free[t*CNT_W +: CNT_W];
        infl_q[t] <= ((INFL_W+1)'(dsp) > sum) ? '0
                   : INFL_W'(sum - (INFL_W+1)'(dsp));
      end
    end
  end
endmodule

module credit_tracker_chk #(
  parameter int THREADS = 2,
  parameter int CNT_W   = 6,
  parameter int INFL_W  = 8,
  parameter int WIDTH_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [THREADS-1:0]         rob_vld,
  input logic [THREADS-1:0]         iq_vld,
  input logic [THREADS-1:0]         lsq_vld,
  input logic [THREADS*WIDTH_W-1:0] disp_cnt,
  input logic [THREADS*WIDTH_W-1:0] avail_cnt,
  input logic [THREADS*WIDTH_W-1:0] ren_cnt,
  input logic [THREADS*WIDTH_W-1:0] allow_cnt,
  input logic [THREADS-1:0]         block,
  input logic [THREADS*2-1:0]       limiter,
  input logic [THREADS-1:0]         rob_empty,
  input logic [CNT_W-1:0]           rob_q  [THREADS],
  input logic [CNT_W-1:0]           iq_q   [THREADS],
  input logic [CNT_W-1:0]           lsq_q  [THREADS],
  input logic [INFL_W-1:0]          infl_q [THREADS]
);
  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    p_allow_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      allow_cnt[t*WIDTH_W +: WIDTH_W] <= avail_cnt[t*WIDTH_W +: WIDTH_W]);
    p_free_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !block[t] |-> allow_cnt[t*WIDTH_W +: WIDTH_W] == avail_cnt[t*WIDTH_W +: WIDTH_W]);
    p_zero_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (allow_cnt[t*WIDTH_W +: WIDTH_W] == '0 && avail_cnt[t*WIDTH_W +: WIDTH_W] != '0) |-> block[t]);
    p_lim_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      limiter[t*2 +: 2] != 2'd3);
    p_rob_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rob_vld[t] |=> $stable(rob_q[t]));
    p_iq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !iq_vld[t] |=> $stable(iq_q[t]));
    p_lsq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lsq_vld[t] |=> $stable(lsq_q[t]));
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rob_vld[t] |=> $stable(rob_empty[t]));
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, disp_cnt[t*WIDTH_W +: WIDTH_W]} > ((INFL_W+1)'(infl_q[t]) + (INFL_W+1)'(ren_cnt[t*WIDTH_W +: WIDTH_W])))
      |=> infl_q[t] == '0);
  end
endmodule

bind credit_tracker credit_tracker_chk #(
  .THREADS(THREADS), .CNT_W(CNT_W), .INFL_W(INFL_W), .WIDTH_W(WIDTH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rob_vld(rob_vld), .iq_vld(iq_vld), .lsq_vld(lsq_vld),
  .disp_cnt(disp_cnt), .avail_cnt(avail_cnt), .ren_cnt(ren_cnt),
  .allow_cnt(allow_cnt), .block(block), .limiter(limiter), .rob_empty(rob_empty),
  .rob_q(rob_q), .iq_q(iq_q), .lsq_q(lsq_q), .infl_q(infl_q)
);

// File: tb/test_credit_tracker.sv
module test_credit_tracker;
  localparam int PERIOD = 10;
  localparam int T = 2, CW = 6, IW = 8, WW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int rob_f[T], iq_f[T], lsq_f[T], disp[T], ldisp[T], av[T], ren[T];
  logic rv[T], iv[T], lv[T], re_in[T];

  logic [T-1:0] rob_vld, iq_vld, lsq_vld, rob_empty_in, block, rob_empty;
  logic [T*CW-1:0] rob_free, iq_free, lsq_free;
  logic [T*WW-1:0] disp_cnt, lsq_disp_cnt, avail_cnt, ren_cnt, allow_cnt;
  logic [T*2-1:0] limiter;

  always_comb begin
    for (int t = 0; t < T; t++) begin
      rob_vld[t] = rv[t]; iq_vld[t] = iv[t]; lsq_vld[t] = lv[t]; rob_empty_in[t] = re_in[t];
      rob_free[t*CW +: CW] = CW'(rob_f[t]);
      iq_free[t*CW +: CW]  = CW'(iq_f[t]);
      lsq_free[t*CW +: CW] = CW'(lsq_f[t]);
      disp_cnt[t*WW +: WW]     = WW'(disp[t]);
      lsq_disp_cnt[t*WW +: WW] = WW'(ldisp[t]);
      avail_cnt[t*WW +: WW]    = WW'(av[t]);
      ren_cnt[t*WW +: WW]      = WW'(ren[t]);
    end
  end

  credit_tracker #(.THREADS(T), .CNT_W(CW), .INFL_W(IW), .WIDTH_W(WW),
                   .ROB_INIT(32), .IQ_INIT(16), .LSQ_INIT(12)) i_credit_tracker (
    .clk(clk), .rst_n(rst_n), .rob_vld(rob_vld), .rob_free(rob_free),
    .rob_empty_in(rob_empty_in), .iq_vld(iq_vld), .iq_free(iq_free),
    .lsq_vld(lsq_vld), .lsq_free(lsq_free), .disp_cnt(disp_cnt),
    .lsq_disp_cnt(lsq_disp_cnt), .avail_cnt(avail_cnt), .ren_cnt(ren_cnt),
    .allow_cnt(allow_cnt), .block(block), .limiter(limiter), .rob_empty(rob_empty));

  int n_chk = 0, n_fail = 0;
  int m_rob[T], m_iq[T], m_lsq[T], m_inf[T];
  logic m_emp[T];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    for (int t = 0; t < T; t++) begin
      rv[t] = 0; iv[t] = 0; lv[t] = 0; re_in[t] = 0;
      disp[t] = 0; ldisp[t] = 0; ren[t] = 0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int t = 0; t < T; t++) begin
      if (rv[t]) begin m_rob[t] = rob_f[t]; m_emp[t] = re_in[t]; end
      if (iv[t]) m_iq[t] = iq_f[t];
      if (lv[t]) m_lsq[t] = lsq_f[t];
      m_inf[t] = m_inf[t] + ren[t] - disp[t];
      if (m_inf[t] < 0) m_inf[t] = 0;
    end
    @(negedge clk);
    clear_in();
  endtask

  task automatic check_out(int t, string req);
    int r, i, s, mn, lim, a, b;
    #1;
    r = m_rob[t] - (m_inf[t] - disp[t]);
    i = m_iq[t]  - (m_inf[t] - disp[t]);
    s = m_lsq[t] - (m_inf[t] - ldisp[t]);
    if (r <= i && r <= s) begin mn = r; lim = 0; end
    else if (i <= s) begin mn = i; lim = 1; end
    else begin mn = s; lim = 2; end
    a = (mn <= 0) ? 0 : (mn < av[t]) ? mn : av[t];
    b = (av[t] > 0 && mn < av[t]) ? 1 : 0;
    check({req, " allow"}, int'(allow_cnt[t*WW +: WW]), a);
    check({req, " block"}, int'(block[t]), b);
    check({req, " limiter"}, int'(limiter[t*2 +: 2]), lim);
  endtask

  task automatic t_reset();
    av[0] = 4; av[1] = 15;
    check_out(0, "R9");
    check_out(1, "R9");
    check("R9 allow literal", int'(allow_cnt[WW-1:0]), 4);
    check("R9 limiter lsq", int'(limiter[1:0]), 2);
    check("R9 rob_empty", int'(rob_empty[0]), 1);
  endtask

  task automatic t_report();
    rv[0] = 1; rob_f[0] = 5; re_in[0] = 0; iv[0] = 1; iq_f[0] = 9;
    step();
    av[0] = 8;
    check_out(0, "R7 report load");
    check("R7 rob-limited allow", int'(allow_cnt[WW-1:0]), 5);
    check("R8 rob_empty cleared", int'(rob_empty[0]), 0);
    rob_f[0] = 1; re_in[0] = 1; iq_f[0] = 1; lsq_f[0] = 1;
    step();
    check_out(0, "R7 no-valid ignored");
    check("R8 rob_empty held", int'(rob_empty[0]), 0);
    check_out(1, "R10 other thread");
  endtask

  task automatic t_inflight();
    ren[0] = 3;
    step();
    av[0] = 4;
    check_out(0, "R1 in-flight subtract");
    check("R1 allow after 3 renamed", int'(allow_cnt[WW-1:0]), 2);
    disp[0] = 2; ren[0] = 2;
    check_out(0, "R1 dispatch returns credit");
    check("R1 allow with dispatch", int'(allow_cnt[WW-1:0]), 4);
    step();
    check_out(0, "R3 same-cycle rename and dispatch");
  endtask

  task automatic t_lsq();
    lv[0] = 1; lsq_f[0] = 2;
    step();
    av[0] = 3;
    check_out(0, "R2 lsq limited");
    check("R2 limiter lsq", int'(limiter[1:0]), 2);
    ldisp[0] = 1;
    check_out(0, "R2 lsq dispatch");
    ldisp[0] = 0; disp[0] = 3;
    check_out(0, "R2 disp_cnt not applied to lsq");
  endtask

  task automatic t_zero();
    rv[0] = 1; rob_f[0] = 0; re_in[0] = 1;
    step();
    av[0] = 2;
    check_out(0, "R5 non-positive credit");
    check("R5 allow zero", int'(allow_cnt[WW-1:0]), 0);
    check("R5 block", int'(block[0]), 1);
    check("R8 rob_empty set", int'(rob_empty[0]), 1);
    av[0] = 0;
    check_out(0, "R4 nothing waiting");
  endtask

  task automatic t_clamp_tie();
    disp[0] = 9;
    step();
    rv[0] = 1; iv[0] = 1; lv[0] = 1; rob_f[0] = 7; iq_f[0] = 7; lsq_f[0] = 7;
    step();
    av[0] = 8;
    check_out(0, "R3 clamp at zero");
    check("R3 allow after clamp", int'(allow_cnt[WW-1:0]), 7);
    check("R6 tie picks rob", int'(limiter[1:0]), 0);
    iv[0] = 1; lv[0] = 1; iq_f[0] = 3; lsq_f[0] = 3;
    step();
    check_out(0, "R6 iq over lsq");
    check("R6 limiter iq", int'(limiter[1:0]), 1);
    av[0] = 2;
    check_out(0, "R4 avail below credit");
  endtask

  task automatic t_thread1();
    rv[1] = 1; rob_f[1] = 1; ren[1] = 1; disp[0] = 2;
    step();
    av[1] = 3;
    check_out(1, "R10 thread1 own report");
    check_out(0, "R10 thread0 untouched");
  endtask

  initial begin
    clear_in();
    for (int t = 0; t < T; t++) begin
      rob_f[t] = 0; iq_f[t] = 0; lsq_f[t] = 0; av[t] = 0;
      m_rob[t] = 32; m_iq[t] = 16; m_lsq[t] = 12; m_inf[t] = 0; m_emp[t] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_report();
    t_inflight();
    t_lsq();
    t_zero();
    t_clamp_tie();
    t_thread1();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule